// File: doc/BRIEF.md
# Fast Page Mode DRAM Controller

This block turns a small synchronous request port into the strobe sequences an asynchronous page-mode DRAM needs. The array has one multiplexed address bus and active-low row strobe, column strobe, write enable and output enable. Each accepted request becomes one complete access: the row is opened, one column is read or written, and the row is closed again. Every timing figure is a whole number of system clock cycles and is set by a parameter.

After reset the controller stays silent for a configurable power-up wait. It then runs a burst of dummy refreshes, in which the column strobe falls before the row strobe, and after that it raises `initDone`. From then on, a free-running interval timer raises a refresh demand. That demand is served at the next idle point, ahead of any waiting user request. Writes are always early writes: write enable falls before the column strobe, so the DRAM never drives the data bus while the controller does. Reads are sampled only after the slowest access path has settled, and the result comes back as a one-cycle `rvalid` pulse.

Top module: `fpm_dram_ctrl`

## Requirements
- R1: While `rstN` is low, `dramRasN`, `dramCasN`, `dramWeN` and `dramOeN` are high, `dramDqOe` is low, and `ready`, `initDone` and `rvalid` are low.
- R2: Neither `dramRasN` nor `dramCasN` falls during the first `PWRUP_CYC` clock cycles after reset is released.
- R3: Before `initDone` rises, exactly `INIT_CYC` refresh cycles are issued, each with `dramCasN` falling before `dramRasN`. `ready` is never high while `initDone` is low.
- R4: When `dramRasN` falls for an access, `dramAddr` carries the row, `addr[ROW_W+COL_W-1:COL_W]`. It holds the row for `RAH_CYC` cycles. When `dramCasN` falls, `dramAddr` carries the column, `addr[COL_W-1:0]`.
- R5: For a write, `dramWeN` is low at least one cycle before `dramCasN` falls. `dramOeN` stays high whenever `dramDqOe` is high. `dramDqOut` carries the request's `wdata`, so the addressed word takes that value.
- R6: In a read, `dramWeN` stays high from the fall of `dramRasN` until its rise. `dramWeN` never falls in the same cycle in which `dramCasN` rises.
- R7: A read accepted at clock edge A is sampled at edge A+`RAH_CYC`+`CSU_CYC`+K, where K = max(`TCAC_CYC`, `TAA_CYC`−`CSU_CYC`, `TRAC_CYC`−`RAH_CYC`−`CSU_CYC`, 1). `rvalid` is high for exactly the one cycle after that edge. `rdata` holds the word last written to that address.
- R8: `dramRasN` stays high for at least `RP_CYC` cycles between any two low periods.
- R9: After `initDone`, a refresh (column strobe before row strobe) is issued once per `REF_CYC` cycles, delayed by no more than the access in progress. A pending refresh wins over a waiting request.
- R10: A request is taken only in a cycle where `req` and `ready` are both high. `ready` falls in the following cycle, and `ready` is never high while either strobe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Request valid |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | ROW_W+COL_W | Word address, row in upper bits |
| wdata | input | DATA_W | Write data |
| ready | output | 1 | Controller can take a request this cycle |
| rvalid | output | 1 | One-cycle read data valid |
| rdata | output | DATA_W | Read data |
| initDone | output | 1 | Power-up sequence complete |
| dramAddr | output | max(ROW_W,COL_W) | Multiplexed row/column address |
| dramRasN | output | 1 | Row strobe, active low |
| dramCasN | output | 1 | Column strobe, active low |
| dramWeN | output | 1 | Write enable, active low |
| dramOeN | output | 1 | Output enable, active low |
| dramDqOut | output | DATA_W | Data driven toward the DRAM |
| dramDqOe | output | 1 | Drive enable for `dramDqOut` |
| dramDqIn | input | DATA_W | Data returned by the DRAM |

## Verification
The assertions assume that `req`, `we`, `addr` and `wdata` stay stable from the cycle `req` rises until the cycle the request is taken. They also assume that reset is held low for at least one clock edge. The bench's request task sets all four fields together at a falling clock edge and keeps them unchanged until it sees `ready`. The DRAM model returns a valid word on `dramDqIn` only once all three access delays have elapsed. Until then it returns a fixed pattern, so a sample taken too early shows up as a data mismatch.

// File: rtl/fpm_dram_pkg.sv
package fpm_dram_pkg;

  typedef enum logic [2:0] {
    S_PWR, S_IDLE, S_ROW, S_COL, S_CAS, S_PRE, S_RFC, S_RFR
  } ctlStateT;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic rasN;
    logic casN;
    logic weN;
    logic oeN;
    logic selCol;
    logic drvDq;
    logic capture;
    logic load;
  } dramStrbT;

  function automatic int maxOf(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/fpm_dram_ctl.sv
module fpm_dram_ctl
  import fpm_dram_pkg::*;
#(
  parameter int PWRUP_CYC = 25000,
  parameter int INIT_CYC  = 8,
  parameter int REF_CYC   = 1950,
  parameter int RAH_CYC   = 2,
  parameter int CSU_CYC   = 1,
  parameter int CAS_CYC   = 6,
  parameter int RP_CYC    = 6,
  parameter int CSR_CYC   = 1,
  parameter int RFR_CYC   = 9
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     req,
  input  logic     we,
  output logic     ready,
  output logic     initDone,
  output dramStrbT strb
);

  localparam int LONGEST = maxOf(PWRUP_CYC, maxOf(maxOf(RAH_CYC, CSU_CYC),
                           maxOf(maxOf(CAS_CYC, RP_CYC), maxOf(CSR_CYC, RFR_CYC))));
  localparam int CNT_W  = $clog2(LONGEST + 1);
  localparam int INIT_W = $clog2(INIT_CYC + 1);
  localparam int REF_W  = $clog2(REF_CYC + 1);

  ctlStateT         stateQ, stateD;
  logic [CNT_W-1:0] cntQ, lenD;
  logic [INIT_W-1:0] initLeft;
  logic [REF_W-1:0] refCnt;
  logic             initQ, refPend, weQ, done, refTick, enterRfc;

  assign done     = (cntQ == '0);
  assign refTick  = initQ && (refCnt == REF_W'(REF_CYC - 1));
  assign enterRfc = (stateD == S_RFC) && (stateQ != S_RFC);
  assign ready    = (stateQ == S_IDLE) && !refPend;
  assign initDone = initQ;

  // next-state: every timed phase leaves when its down-counter hits zero
  always_comb begin
    stateD = stateQ;
    unique case (stateQ)
      S_PWR:  if (done) stateD = S_RFC;
      S_IDLE: if (refPend) stateD = S_RFC;
              else if (req) stateD = S_ROW;
      S_ROW:  if (done) stateD = S_COL;
      S_COL:  if (done) stateD = S_CAS;
      S_CAS:  if (done) stateD = S_PRE;
      S_PRE:  if (done) stateD = (!initQ && initLeft != '0) ? S_RFC : S_IDLE;
      S_RFC:  if (done) stateD = S_RFR;
      S_RFR:  if (done) stateD = S_PRE;
      default: stateD = S_IDLE;
    endcase
  end

  always_comb begin
    unique case (stateD)
      S_PWR:   lenD = CNT_W'(PWRUP_CYC - 1);
      S_ROW:   lenD = CNT_W'(RAH_CYC - 1);
      S_COL:   lenD = CNT_W'(CSU_CYC - 1);
      S_CAS:   lenD = CNT_W'(CAS_CYC - 1);
      S_PRE:   lenD = CNT_W'(RP_CYC - 1);
      S_RFC:   lenD = CNT_W'(CSR_CYC - 1);
      S_RFR:   lenD = CNT_W'(RFR_CYC - 1);
      default: lenD = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ <= S_PWR;
      cntQ   <= CNT_W'(PWRUP_CYC - 1);
    end else begin
      stateQ <= stateD;
      if (stateD != stateQ) cntQ <= lenD;
      else if (!done)       cntQ <= cntQ - 1'b1;
    end
  end

  // init burst bookkeeping and refresh interval timer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      initLeft <= INIT_W'(INIT_CYC);
      initQ    <= 1'b0;
      refCnt   <= '0;
      refPend  <= 1'b0;
      weQ      <= 1'b0;
    end else begin
      if (enterRfc && !initQ) initLeft <= initLeft - 1'b1;
      if (stateQ == S_PRE && done && !initQ && initLeft == '0) initQ <= 1'b1;
      if (initQ) refCnt <= refTick ? '0 : refCnt + 1'b1;
      if (stateQ == S_IDLE && refPend) refPend <= 1'b0;
      if (refTick) refPend <= 1'b1;
      if (strb.load) weQ <= we;
    end
  end

  always_comb begin
    strb.rasN    = !(stateQ inside {S_ROW, S_COL, S_CAS, S_RFR});
    strb.casN    = !(stateQ inside {S_CAS, S_RFC, S_RFR});
    strb.weN     = !(weQ && (stateQ inside {S_COL, S_CAS}));
    strb.oeN     = !(!weQ && stateQ == S_CAS);
    strb.selCol  = stateQ inside {S_COL, S_CAS};
    strb.drvDq   = weQ && (stateQ inside {S_COL, S_CAS});
    strb.capture = !weQ && stateQ == S_CAS && done;
    strb.load    = ready && req;
  end

endmodule

// File: rtl/fpm_dram_dp.sv
module fpm_dram_dp
  import fpm_dram_pkg::*;
#(
  parameter int ROW_W  = 8,
  parameter int COL_W  = 8,
  parameter int DATA_W = 16
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  dramStrbT                   strb,
  input  logic [ROW_W+COL_W-1:0]     addr,
  input  logic [DATA_W-1:0]          wdata,
  input  logic [DATA_W-1:0]          dramDqIn,
  output logic [maxOf(ROW_W,COL_W)-1:0] dramAddr,
  output logic [DATA_W-1:0]          dramDqOut,
  output logic                       dramDqOe,
  output logic [DATA_W-1:0]          rdata,
  output logic                       rvalid
);

  localparam int DRAM_AW = maxOf(ROW_W, COL_W);
  localparam int AW      = ROW_W + COL_W;

  logic [AW-1:0]     addrQ;
  logic [DATA_W-1:0] wdataQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ  <= '0;
      wdataQ <= '0;
      rdata  <= '0;
      rvalid <= 1'b0;
    end else begin
      if (strb.load) begin
        addrQ  <= addr;
        wdataQ <= wdata;
      end
      rvalid <= strb.capture;
      if (strb.capture) rdata <= dramDqIn;
    end
  end

  assign dramAddr  = strb.selCol ? DRAM_AW'(addrQ[COL_W-1:0]) : DRAM_AW'(addrQ[AW-1:COL_W]);
  assign dramDqOut = wdataQ;
  assign dramDqOe  = strb.drvDq;

endmodule

// File: rtl/fpm_dram_ctrl.sv
module fpm_dram_ctrl
  import fpm_dram_pkg::*;
#(
  parameter int ROW_W     = 8,
  parameter int COL_W     = 8,
  parameter int DATA_W    = 16,
  parameter int PWRUP_CYC = 25000,
  parameter int INIT_CYC  = 8,
  parameter int REF_CYC   = 1950,
  parameter int RAH_CYC   = 2,
  parameter int CSU_CYC   = 1,
  parameter int TCAC_CYC  = 3,
  parameter int TAA_CYC   = 4,
  parameter int TRAC_CYC  = 8,
  parameter int RP_CYC    = 6,
  parameter int CSR_CYC   = 1,
  parameter int RFR_CYC   = 9
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          req,
  input  logic                          we,
  input  logic [ROW_W+COL_W-1:0]        addr,
  input  logic [DATA_W-1:0]             wdata,
  output logic                          ready,
  output logic                          rvalid,
  output logic [DATA_W-1:0]             rdata,
  output logic                          initDone,
  output logic [maxOf(ROW_W,COL_W)-1:0] dramAddr,
  output logic                          dramRasN,
  output logic                          dramCasN,
  output logic                          dramWeN,
  output logic                          dramOeN,
  output logic [DATA_W-1:0]             dramDqOut,
  output logic                          dramDqOe,
  input  logic [DATA_W-1:0]             dramDqIn
);

  // column-strobe width covering the slowest of the three access paths
  localparam int CAS_CYC = maxOf(maxOf(TCAC_CYC, TAA_CYC - CSU_CYC),
                                 maxOf(TRAC_CYC - RAH_CYC - CSU_CYC, 1));

  dramStrbT strb;

  fpm_dram_ctl #(
    .PWRUP_CYC(PWRUP_CYC), .INIT_CYC(INIT_CYC), .REF_CYC(REF_CYC),
    .RAH_CYC(RAH_CYC), .CSU_CYC(CSU_CYC), .CAS_CYC(CAS_CYC),
    .RP_CYC(RP_CYC), .CSR_CYC(CSR_CYC), .RFR_CYC(RFR_CYC)
  ) uCtl (
    .clk(clk), .rstN(rstN), .req(req), .we(we),
    .ready(ready), .initDone(initDone), .strb(strb)
  );

  fpm_dram_dp #(.ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W)) uDp (
    .clk(clk), .rstN(rstN), .strb(strb), .addr(addr), .wdata(wdata),
    .dramDqIn(dramDqIn), .dramAddr(dramAddr), .dramDqOut(dramDqOut),
    .dramDqOe(dramDqOe), .rdata(rdata), .rvalid(rvalid)
  );

  assign dramRasN = strb.rasN;
  assign dramCasN = strb.casN;
  assign dramWeN  = strb.weN;
  assign dramOeN  = strb.oeN;

endmodule

// File: rtl/fpm_dram_chk.sv
module fpm_dram_chk #(
  parameter int PWRUP_CYC = 25000,
  parameter int RP_CYC    = 6
) (
  input logic clk,
  input logic rstN,
  input logic req,
  input logic ready,
  input logic rvalid,
  input logic initDone,
  input logic dramRasN,
  input logic dramCasN,
  input logic dramWeN,
  input logic dramOeN,
  input logic dramDqOe
);

  localparam int SR_W = $clog2(PWRUP_CYC + 1) + 1;
  localparam int RH_W = $clog2(RP_CYC + 1) + 1;

  logic [SR_W-1:0] sinceRst;
  logic [RH_W-1:0] rasHigh;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sinceRst <= '0;
      rasHigh  <= RH_W'(RP_CYC);
    end else begin
      if (sinceRst < SR_W'(PWRUP_CYC)) sinceRst <= sinceRst + 1'b1;
      if (!dramRasN) rasHigh <= '0;
      else if (rasHigh < RH_W'(RP_CYC)) rasHigh <= rasHigh + 1'b1;
    end
  end

  p_quiet_pwrup_r2: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst < SR_W'(PWRUP_CYC)) |-> (dramRasN && dramCasN));

  p_ready_after_init_r3: assert property (@(posedge clk) disable iff (!rstN)
    ready |-> initDone);

  p_early_we_r5: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(dramCasN) && !dramRasN && !dramWeN) |-> ($past(dramWeN) == 1'b0));

  p_no_bus_clash_r5: assert property (@(posedge clk) disable iff (!rstN)
    dramDqOe |-> dramOeN);

  p_rvalid_pulse_r7: assert property (@(posedge clk) disable iff (!rstN)
    rvalid |=> !rvalid);

  p_precharge_r8: assert property (@(posedge clk) disable iff (!rstN)
    $fell(dramRasN) |-> (rasHigh >= RH_W'(RP_CYC)));

  p_cbr_order_r9: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(dramRasN) && !dramCasN) |-> ($past(dramCasN) == 1'b0));

  p_accept_busy_r10: assert property (@(posedge clk) disable iff (!rstN)
    (req && ready) |=> !ready);

endmodule

bind fpm_dram_ctrl fpm_dram_chk #(.PWRUP_CYC(PWRUP_CYC), .RP_CYC(RP_CYC)) u_chk (.*);

// File: tb/sim_fpm_dram_ctrl.sv
module sim_fpm_dram_ctrl;
  localparam int RW = 4, CW = 4, DW = 16, AW = 8, DAW = 4;
  localparam int PWR = 100, NINIT = 8, REF = 300, RAH = 1, CSU = 1;
  localparam int TCAC = 2, TAA = 3, TRAC = 5, RP = 3, CSR = 1, RFR = 3;
  localparam int K0  = (TCAC > TAA - CSU) ? TCAC : TAA - CSU;
  localparam int K1  = (K0 > TRAC - RAH - CSU) ? K0 : TRAC - RAH - CSU;
  localparam int K   = (K1 > 1) ? K1 : 1;
  localparam int LAT = RAH + CSU + K;

  logic clk = 1'b0, rstN = 1'b0, req = 1'b0, we = 1'b0;
  logic [AW-1:0]  addr = '0;
  logic [DW-1:0]  wdata = '0, dqIn = 16'hDEAD;
  logic ready, rvalid, initDone, dramRasN, dramCasN, dramWeN, dramOeN, dqOe;
  logic [DW-1:0]  rdata, dqOut;
  logic [DAW-1:0] dramAddr;

  always #4 clk = ~clk;

  fpm_dram_ctrl #(
    .ROW_W(RW), .COL_W(CW), .DATA_W(DW), .PWRUP_CYC(PWR), .INIT_CYC(NINIT),
    .REF_CYC(REF), .RAH_CYC(RAH), .CSU_CYC(CSU), .TCAC_CYC(TCAC), .TAA_CYC(TAA),
    .TRAC_CYC(TRAC), .RP_CYC(RP), .CSR_CYC(CSR), .RFR_CYC(RFR)
  ) u0 (
    .clk(clk), .rstN(rstN), .req(req), .we(we), .addr(addr), .wdata(wdata),
    .ready(ready), .rvalid(rvalid), .rdata(rdata), .initDone(initDone),
    .dramAddr(dramAddr), .dramRasN(dramRasN), .dramCasN(dramCasN),
    .dramWeN(dramWeN), .dramOeN(dramOeN), .dramDqOut(dqOut), .dramDqOe(dqOe),
    .dramDqIn(dqIn)
  );

  int nChk = 0, nBad = 0;
  longint cyc = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    nChk++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic finishRun();
    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  endtask

  function automatic logic [DW-1:0] pat(input int i);
    return DW'(i * 16'h0101) ^ 16'h5A5A;
  endfunction

  always @(posedge clk) if (rstN) cyc <= cyc + 1;

  // reference state and DRAM contents
  logic [DW-1:0] refMem [256];
  logic [DW-1:0] dmem   [256];
  longint dueQ[$];
  logic [DW-1:0] rdQ[$];
  logic [AW-1:0] aAddr[$];
  bit            aWe[$];
  logic [DW-1:0] aData[$];

  // behavioural DRAM model and per-clock comparison
  logic prevRas = 1, prevCas = 1, prevWe = 1, prevInit = 0;
  logic [DAW-1:0] prevDA = '0, latRow = '0, latCol = '0;
  int rasHigh = 1000, rasCyc = 0, casCyc = 0, colCyc = 0, initRefs = 0, refsAfter = 0;
  bit firstCmd = 0, curValid = 0, curWe = 0, weLowRead = 0;
  logic [AW-1:0] curA = '0;
  logic [DW-1:0] curD = '0;
  longint lastRef = -1, lastCasRise = -100, initDoneCyc = 0;

  always @(negedge clk) begin
    if (rstN && !finished) begin
      bit rf, cf, rr, cr, expV;
      logic [DW-1:0] expD;
      rf = prevRas && !dramRasN;  rr = !prevRas && dramRasN;
      cf = prevCas && !dramCasN;  cr = !prevCas && dramCasN;
      if ((rf || cf) && !firstCmd) begin
        firstCmd = 1;
        check(cyc >= PWR, "R2 first command too early", cyc, PWR);
      end
      if (rf) begin
        check(rasHigh >= RP, "R8 precharge", rasHigh, RP);
        latRow = dramAddr;
        if (!dramCasN) begin
          if (!initDone) initRefs++;
          else begin
            refsAfter++;
            if (lastRef >= 0)
              check((cyc - lastRef >= REF - 12) && (cyc - lastRef <= REF + 12),
                    "R9 refresh spacing", cyc - lastRef, REF);
            lastRef = cyc;
          end
        end else if (aAddr.size() == 0) begin
          check(0, "R10 row opened without request", 1, 0);
        end else begin
          curA = aAddr.pop_front(); curWe = aWe.pop_front(); curD = aData.pop_front();
          curValid = 1; weLowRead = 0;
          check(dramAddr == curA[AW-1:CW], "R4 row address", dramAddr, curA[AW-1:CW]);
        end
      end
      if (cf && !dramRasN && curValid) begin
        latCol = dramAddr;
        check(dramAddr == curA[CW-1:0], "R4 column address", dramAddr, curA[CW-1:0]);
        if (curWe) begin
          check(!dramWeN && !prevWe, "R5 WE low before CAS", prevWe, 0);
          check(dramOeN && dqOe, "R5 bus ownership", {dramOeN, dqOe}, 2'b11);
          check(dqOut == curD, "R5 write data", dqOut, curD);
          dmem[{latRow, latCol}] = dqOut;
        end else check(dramWeN, "R6 WE high at read CAS", dramWeN, 1);
      end
      if (curValid && !curWe && !dramWeN) weLowRead = 1;
      if (rr && curValid) begin
        if (!curWe) check(!weLowRead, "R6 WE held through read", weLowRead, 0);
        curValid = 0;
      end
      if (prevWe && !dramWeN) check(cyc - lastCasRise >= 1, "R6 WE fell at CAS rise", cyc - lastCasRise, 1);
      if (cr) lastCasRise = cyc;
      if (dqOe && !dramOeN) check(0, "R5 both drivers on", 1, 0);
      if (ready && (!dramRasN || !dramCasN)) check(0, "R10 ready while busy", 1, 0);
      if (ready && !initDone) check(0, "R3 ready before init", 1, 0);
      if (initDone && !prevInit) begin
        check(initRefs == NINIT, "R3 init refresh count", initRefs, NINIT);
        initDoneCyc = cyc;
      end
      expV = (dueQ.size() > 0) && (dueQ[0] == cyc);
      check(rvalid == expV, "R7 rvalid timing", rvalid, expV);
      if (expV) begin
        void'(dueQ.pop_front());
        expD = rdQ.pop_front();
        check(rdata == expD, "R7 read data", rdata, expD);
      end
      rasHigh = dramRasN ? rasHigh + 1 : 0;
      rasCyc  = dramRasN ? 0 : rasCyc + 1;
      casCyc  = dramCasN ? 0 : casCyc + 1;
      colCyc  = (dramAddr != prevDA) ? 1 : colCyc + 1;
      dqIn = (!dramCasN && !dramOeN && dramWeN && casCyc >= TCAC && rasCyc >= TRAC && colCyc >= TAA)
             ? dmem[{latRow, latCol}] : 16'hDEAD;
      prevRas = dramRasN; prevCas = dramCasN; prevWe = dramWeN;
      prevDA = dramAddr; prevInit = initDone;
    end
  end

  // called at a falling edge; returns at the falling edge after acceptance
  task automatic doReq(input bit w, input logic [AW-1:0] a, input logic [DW-1:0] d);
    req = 1; we = w; addr = a; wdata = d;
    while (!ready) @(negedge clk);
    aAddr.push_back(a); aWe.push_back(w); aData.push_back(d);
    if (w) refMem[a] = d;
    else begin
      dueQ.push_back(cyc + 1 + LAT);
      rdQ.push_back(refMem[a]);
    end
    @(negedge clk);
  endtask

  initial begin
    logic [15:0] lf;
    for (int i = 0; i < 256; i++) begin
      refMem[i] = pat(i); dmem[i] = pat(i);
    end
    repeat (4) @(negedge clk);
    check(dramRasN && dramCasN && dramWeN && dramOeN && !dqOe, "R1 strobes in reset",
          {dramRasN, dramCasN, dramWeN, dramOeN, dqOe}, 5'b11110);
    check(!ready && !initDone && !rvalid, "R1 status in reset", {ready, initDone, rvalid}, 0);
    rstN = 1;
    while (!initDone) @(negedge clk);
    check(cyc >= PWR + NINIT * (CSR + RFR + RP), "R2 init duration", cyc, PWR + NINIT * (CSR + RFR + RP));
    // writes to corner addresses
    doReq(1, 8'h00, 16'h1111);
    doReq(1, 8'hFF, 16'hFFFF);
    doReq(1, 8'h5A, 16'hA5A5);
    doReq(1, 8'hF0, 16'h0F0F);
    // read back, including a location never written
    doReq(0, 8'h00, '0);
    doReq(0, 8'hFF, '0);
    doReq(0, 8'h5A, '0);
    doReq(0, 8'hF0, '0);
    doReq(0, 8'h33, '0);
    // overwrite then read
    doReq(1, 8'h5A, 16'h1234);
    doReq(0, 8'h5A, '0);
    req = 0;
    // idle span: refreshes alone
    repeat (700) @(negedge clk);
    // dense mixed stream crossing several refresh demands
    lf = 16'hACE1;
    for (int n = 0; n < 200; n++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      doReq(lf[0] | lf[5], lf[15:8], lf ^ 16'h3C3C);
    end
    req = 0;
    repeat (40) @(negedge clk);
    check(dueQ.size() == 0, "R7 reads outstanding", dueQ.size(), 0);
    check(refsAfter >= (cyc - initDoneCyc) / REF - 1, "R9 refresh count", refsAfter, (cyc - initDoneCyc) / REF - 1);
    finishRun();
  end

  initial begin
    while (cyc < 150000 && !finished) @(posedge clk);
    if (!finished) begin
      check(0, "watchdog expired", cyc, 0);
      finishRun();
    end
  end

endmodule